// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns one 18-bit instruction word into the 17-bit physical address of its memory operand. It decodes the opcode and the two addressing-mode flags. For a direct reference it builds a page-relative address from the program counter. For an indexed reference it adds the index register. For an indirect reference it reads one pointer word from memory, and in the indirect-indexed mode it then adds the index register to that pointer. Opcodes that do not reference memory are flagged, and no address is formed for them.

A sequencer pulses `start` with the instruction word, the program counter and the index register on the inputs. It then waits for the `done` pulse, which comes with either a valid `ea` or the `no_addr` flag. Only an indirect reference makes the block busy. While busy it holds a read request on the memory port until the memory acknowledges it.

Top module: `ea_gen`

## Requirements
- R1: After reset, `busy`, `done`, `no_addr` and `mem_req` are 0 and `ea` is 0.
- R2: Instruction fields: `instr[17:14]` is the opcode, `instr[13]` is the indirect flag, `instr[12]` is the index flag and `instr[11:0]` is the address field.
- R3: Direct mode (indirect 0, index 0): one cycle after `start` is accepted, `done` is 1 and `ea` = {`pc[16:12]`, `instr[11:0]`}. No memory read is issued.
- R4: Indexed mode (indirect 0, index 1): one cycle after `start` is accepted, `done` is 1 and `ea` = ({`pc[16:12]`, `instr[11:0]`} + `xr`) mod 2^17. No memory read is issued.
- R5: Indirect mode (indirect 1, index 0): one cycle after `start` is accepted, `mem_req` is 1 and `busy` is 1, with `mem_addr` = {`pc[16:12]`, `instr[11:0]`}. One cycle after the cycle in which `mem_ack` is 1, `done` is 1, `busy` and `mem_req` are 0, and `ea` = {`pc[16:15]`, `mem_rdata[14:0]`}. The `pc` used is the value sampled at `start`.
- R6: Indirect-indexed mode (both flags 1): the pointer is formed as in R5. `ea` = (pointer + `xr` sampled at `start`) mod 2^17.
- R7: `mem_req` and `mem_addr` stay unchanged through any number of wait cycles until `mem_ack`. Exactly one read is made for each instruction.
- R8: Opcodes in the parameter set `NOMEM_MASK` (default 13, 14 and 15) give `done` and `no_addr` one cycle after `start`. They issue no memory read and leave `ea` unchanged.
- R9: `done` lasts one cycle unless a new `start` is accepted in that cycle. `no_addr` is 1 only together with `done`, and only for the opcodes of R8.
- R10: `start` while `busy` is ignored. The running instruction completes with its own result, and no extra `done` follows.
- R11: `mem_ack` while no request is pending has no effect: no `done` and no change of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation, accepted when not busy |
| instr | input | 18 | Instruction word |
| pc | input | 17 | Program counter |
| xr | input | 17 | Index register |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| no_addr | output | 1 | Instruction does not reference memory (with done) |
| ea | output | 17 | Effective address (valid with done, held after) |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 17 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| mem_rdata | input | 18 | Read data |

## Verification
A wrong mode decode shows at the ports one cycle after `start`, as a `mem_req` that should not be there or a missing one. A wrong latch of the pointer, program counter or index register appears as a wrong `ea` in the `done` cycle that follows the acknowledge. A state register stuck busy or idle shows as a `done` that never comes, or one that comes on a stray acknowledge, within a single cycle of the event.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW  = 17,
  parameter int WW  = 18,
  parameter int OPW = 4,
  parameter int FW  = 12,
  parameter int IW  = 15,
  parameter logic [(1<<OPW)-1:0] NOMEM_MASK = {3'b111, {((1<<OPW)-3){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] instr,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] xr,
  output logic          busy,
  output logic          done,
  output logic          no_addr,
  output logic [AW-1:0] ea,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata
);
  localparam int IND_BIT = WW - OPW - 1;
  localparam int IDX_BIT = WW - OPW - 2;

  wire [OPW-1:0] op       = instr[WW-1 -: OPW];
  wire           ind      = instr[IND_BIT];
  wire           idx      = instr[IDX_BIT];
  wire [AW-1:0]  dir_addr = {pc[AW-1:FW], instr[FW-1:0]};
  wire           nomem    = NOMEM_MASK[op];
  wire           accept   = start && !busy;

  logic             idx_q;
  logic [AW-1:IW]   pc_hi_q;
  logic [AW-1:0]    xr_q;

  wire [AW-1:0] ptr = {pc_hi_q, mem_rdata[IW-1:0]};
  wire unused_bits  = ^{pc[FW-1:0], mem_rdata[WW-1:IW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      no_addr  <= 1'b0;
      ea       <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      idx_q    <= 1'b0;
      pc_hi_q  <= '0;
      xr_q     <= '0;
    end else begin
      done    <= 1'b0;
      no_addr <= 1'b0;
      if (accept) begin
        if (nomem) begin
          done    <= 1'b1;
          no_addr <= 1'b1;
        end else if (ind) begin
          busy     <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= dir_addr;
          idx_q    <= idx;
          pc_hi_q  <= pc[AW-1:IW];
          xr_q     <= xr;
        end else begin
          done <= 1'b1;
          ea   <= idx ? dir_addr + xr : dir_addr;
        end
      end else if (busy && mem_ack) begin
        busy    <= 1'b0;
        mem_req <= 1'b0;
        done    <= 1'b1;
        ea      <= idx_q ? ptr + xr_q : ptr;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          no_addr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R7
  AST_ACK_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ack |=> done && !busy && !mem_req); // R5
  AST_NOADDR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    no_addr |-> done && !busy); // R9
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ack |=> busy && !done); // R10
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && !done); // R11
  AST_REQ_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R5
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .no_addr(no_addr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [17:0] instr = '0;
  logic [16:0] pc = '0;
  logic [16:0] xr = '0;
  logic        busy, done, no_addr, mem_req, mem_ack = 0;
  logic [16:0] ea, mem_addr;
  logic [17:0] mem_rdata = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ea_gen u_dut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
    .xr(xr), .busy(busy), .done(done), .no_addr(no_addr), .ea(ea),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [17:0] mk(input logic [3:0] op, input logic i, input logic x,
                                     input logic [11:0] a);
    return {op, i, x, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [17:0] w, input logic [16:0] p, input logic [16:0] x);
    @(negedge clk);
    instr = w; pc = p; xr = x; start = 1;
    @(negedge clk);
    start = 0; instr = '0; pc = '0; xr = '0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 no_addr", no_addr, 0);
    chk("R1 mem_req", mem_req, 0); chk("R1 ea", ea, 0);
  endtask

  task automatic t_direct(input logic [16:0] p, input logic [11:0] a);
    pulse_start(mk(4'h2, 0, 0, a), p, 17'h1FFFF);
    chk("R3 done", done, 1); chk("R3 no req", mem_req, 0);
    chk("R3 ea", ea, {p[16:12], a}); chk("R9 no_addr low", no_addr, 0);
    @(negedge clk);
    chk("R9 done pulse", done, 0);
  endtask

  task automatic t_indexed(input logic [16:0] p, input logic [11:0] a, input logic [16:0] x);
    logic [16:0] e;
    e = {p[16:12], a} + x;
    pulse_start(mk(4'h5, 0, 1, a), p, x);
    chk("R4 done", done, 1); chk("R4 no req", mem_req, 0); chk("R4 ea", ea, e);
  endtask

  task automatic t_indirect(input logic [3:0] op, input logic x_en, input logic [16:0] p,
                            input logic [11:0] a, input logic [16:0] x,
                            input logic [17:0] d, input int waits, input logic poke);
    logic [16:0] e;
    string r;
    r = x_en ? "R6" : "R5";
    e = {p[16:15], d[14:0]};
    if (x_en) e = e + x;
    pulse_start(mk(op, 1, x_en, a), p, x);
    chk("R5 req", mem_req, 1); chk("R5 busy", busy, 1); chk("R5 done low", done, 0);
    chk("R2 R5 mem_addr", mem_addr, {p[16:12], a});
    for (int k = 0; k < waits; k++) begin
      if (poke && k == 0) begin start = 1; instr = mk(4'h1, 0, 0, 12'h777); pc = '1; end
      @(negedge clk);
      start = 0;
      chk("R7 req held", mem_req, 1); chk("R7 addr held", mem_addr, {p[16:12], a});
      chk("R10 no done while busy", done, 0);
    end
    mem_ack = 1; mem_rdata = d;
    @(negedge clk);
    mem_ack = 0; mem_rdata = '0;
    chk({r, " done"}, done, 1); chk({r, " ea"}, ea, e);
    chk("R5 idle after", busy, 0); chk("R7 req dropped", mem_req, 0);
    @(negedge clk);
    chk("R10 no extra done", done, 0); chk("R7 single read", mem_req, 0);
  endtask

  task automatic t_nomem(input logic [3:0] op);
    logic [16:0] prev;
    prev = ea;
    pulse_start(mk(op, 1, 1, 12'hABC), 17'h0F0F0, 17'h00123);
    chk("R8 done", done, 1); chk("R8 no_addr", no_addr, 1);
    chk("R8 no req", mem_req, 0); chk("R8 ea kept", ea, prev);
    @(negedge clk);
    chk("R8 still no req", mem_req, 0); chk("R9 no_addr pulse", no_addr, 0);
  endtask

  task automatic t_stray_ack();
    @(negedge clk);
    mem_ack = 1; mem_rdata = 18'h3FFFF;
    @(negedge clk);
    mem_ack = 0;
    chk("R11 no done", done, 0); chk("R11 not busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_direct(17'h1A345, 12'h0AB);
    t_direct(17'h00FFF, 12'hFFF);
    t_indexed(17'h0B000, 12'h010, 17'h00005);
    t_indexed(17'h1F000, 12'hFFF, 17'h00002);
    t_indirect(4'h0, 0, 17'h1C123, 12'h456, 17'h0, 18'h3ABCD, 0, 0);
    t_indirect(4'h3, 0, 17'h0A000, 12'h001, 17'h0, 18'h07FFF, 4, 1);
    t_indirect(4'hC, 1, 17'h18000, 12'h222, 17'h00100, 18'h01234, 2, 0);
    t_indirect(4'h7, 1, 17'h1E000, 12'h333, 17'h1FFFF, 18'h07FFF, 1, 0);
    t_nomem(4'hD);
    t_nomem(4'hE);
    t_nomem(4'hF);
    t_stray_ack();
    t_direct(17'h05000, 12'h800);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule